// File: doc/BRIEF.md
# Main Instruction Control Decoder

This block sits between instruction fetch and the datapath of a single-cycle integer core. It takes the 6-bit major opcode of the current instruction and produces the nine control lines that steer the datapath. Three of them are mux selects: the destination register field, the source of the second ALU operand, and the source of write-back data. Three are enables: register-file write, data-memory read and data-memory write. Two bits give the ALU operation class, which a separate function-field decoder turns into a concrete ALU operation. The last line marks a conditional branch. The decoder recognises four instruction kinds: register-register, word load, word store and branch-if-equal.

The control word is registered. Each rising edge samples the opcode, and the decoded lines appear on the outputs for the following cycle. The next-PC select is not registered. It is the registered branch line ANDed with the ALU zero flag in the same cycle, so a taken branch follows the comparison result directly. Any opcode outside the four known kinds produces an all-zero control word, so such an instruction writes no register, touches no memory and never redirects the PC.

Top module: `main_ctrl_dec`

## Requirements
- R1: While `rst_n` is low, all nine control lines and `pc_take` are 0, and this takes effect without waiting for a clock edge.
- R2: Opcode 0x00 (register-register) gives `dst_sel_rd`=1, `alu_b_imm`=0, `wb_from_mem`=0, `rf_we`=1, `dm_re`=0, `dm_we`=0, `alu_class`=2'b10, `is_branch`=0.
- R3: Opcode 0x23 (load) gives `dst_sel_rd`=0, `alu_b_imm`=1, `wb_from_mem`=1, `rf_we`=1, `dm_re`=1, `dm_we`=0, `alu_class`=2'b00, `is_branch`=0.
- R4: Opcode 0x2B (store) gives `dst_sel_rd`=0, `alu_b_imm`=1, `wb_from_mem`=0, `rf_we`=0, `dm_re`=0, `dm_we`=1, `alu_class`=2'b00, `is_branch`=0.
- R5: Opcode 0x04 (branch-if-equal) gives `dst_sel_rd`=0, `alu_b_imm`=0, `wb_from_mem`=0, `rf_we`=0, `dm_re`=0, `dm_we`=0, `alu_class`=2'b01, `is_branch`=1.
- R6: Any other opcode drives all nine control lines to 0.
- R7: The control lines reflect the opcode sampled at the most recent rising edge of `clk`. They do not change between edges, even when `opcode` changes.
- R8: `pc_take` equals `is_branch` AND `alu_zero` in the same cycle. It is 0 whenever `alu_zero` is 0 or the registered instruction is not a branch.
- R9: `rf_we` and `dm_we` are never both 1. When `dm_re` is 1, both `rf_we` and `wb_from_mem` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Major opcode of the current instruction |
| alu_zero | input | 1 | ALU zero-result flag |
| dst_sel_rd | output | 1 | 1: destination is the rd field; 0: destination is the rt field |
| alu_b_imm | output | 1 | 1: second ALU operand is the sign-extended immediate |
| wb_from_mem | output | 1 | 1: write-back data comes from data memory |
| rf_we | output | 1 | Register-file write enable |
| dm_re | output | 1 | Data-memory read enable |
| dm_we | output | 1 | Data-memory write enable |
| alu_class | output | 2 | ALU class: 00 add, 01 subtract, 10 use the function field |
| is_branch | output | 1 | Conditional branch instruction |
| pc_take | output | 1 | Select the branch target as the next PC |

## Verification
Some properties are checked on every cycle after reset. These are the exclusion between register write and memory write, the coupling of a memory read with a memory-sourced register write, the gating of `pc_take` by the zero flag, the hold of the control word while the opcode is stable, and the decode of each known and unknown opcode against the opcode sampled one edge earlier. Other behaviour needs directed scenarios from the bench. These are the exact nine-bit word for every opcode kind including several illegal codes, the one-edge latency when the opcode changes between edges, and the immediate clearing of the outputs when reset is asserted in the middle of a load.

// File: rtl/main_ctrl_dec_pkg.sv
package main_ctrl_dec_pkg;

    localparam int OP_W      = 6;
    localparam int CLASS_W   = 2;
    localparam int N_KINDS   = 4;

    // major opcode values for the recognised instruction kinds
    localparam logic [OP_W-1:0] OPC_RR     = 6'h00;
    localparam logic [OP_W-1:0] OPC_LOAD   = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE  = 6'h2B;
    localparam logic [OP_W-1:0] OPC_BRANCH = 6'h04;

    // ALU operation classes handed to the function-field decoder
    localparam logic [CLASS_W-1:0] CLS_ADD  = 2'b00;
    localparam logic [CLASS_W-1:0] CLS_SUB  = 2'b01;
    localparam logic [CLASS_W-1:0] CLS_FUNC = 2'b10;

    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_RR     = 3'd1,
        KIND_LOAD   = 3'd2,
        KIND_STORE  = 3'd3,
        KIND_BRANCH = 3'd4
    } instr_kind_e;

    typedef struct packed {
        logic               dst_sel_rd;
        logic               alu_b_imm;
        logic               wb_from_mem;
        logic               rf_we;
        logic               dm_re;
        logic               dm_we;
        logic [CLASS_W-1:0] alu_class;
        logic               is_branch;
    } ctrl_word_t;

    localparam ctrl_word_t CTRL_IDLE = '0;

endpackage

// File: rtl/main_ctrl_dec_classify.sv
module main_ctrl_dec_classify
    import main_ctrl_dec_pkg::*;
#(
    parameter int                 W        = OP_W,
    parameter logic [W-1:0]       C_RR     = OPC_RR,
    parameter logic [W-1:0]       C_LOAD   = OPC_LOAD,
    parameter logic [W-1:0]       C_STORE  = OPC_STORE,
    parameter logic [W-1:0]       C_BRANCH = OPC_BRANCH
) (
    input  logic [W-1:0] opcode,
    output instr_kind_e  kind
);

    localparam int K = N_KINDS;
    localparam logic [W-1:0] CODES [K] = '{C_RR, C_LOAD, C_STORE, C_BRANCH};

    logic [K-1:0] hit;

    // one comparator per recognised kind
    for (genvar i = 0; i < K; i++) begin : g_match
        assign hit[i] = (opcode == CODES[i]);
    end

    always_comb begin
        kind = KIND_NONE;
        unique case (1'b1)
            hit[0]:  kind = KIND_RR;
            hit[1]:  kind = KIND_LOAD;
            hit[2]:  kind = KIND_STORE;
            hit[3]:  kind = KIND_BRANCH;
            default: kind = KIND_NONE;
        endcase
    end

endmodule

// File: rtl/main_ctrl_dec_table.sv
module main_ctrl_dec_table
    import main_ctrl_dec_pkg::*;
(
    input  instr_kind_e kind,
    output ctrl_word_t  word
);

    always_comb begin
        word = CTRL_IDLE;
        case (kind)
            KIND_RR: begin
                word.dst_sel_rd = 1'b1;
                word.rf_we      = 1'b1;
                word.alu_class  = CLS_FUNC;
            end
            KIND_LOAD: begin
                word.alu_b_imm   = 1'b1;
                word.wb_from_mem = 1'b1;
                word.rf_we       = 1'b1;
                word.dm_re       = 1'b1;
                word.alu_class   = CLS_ADD;
            end
            KIND_STORE: begin
                word.alu_b_imm = 1'b1;
                word.dm_we     = 1'b1;
                word.alu_class = CLS_ADD;
            end
            KIND_BRANCH: begin
                word.alu_class = CLS_SUB;
                word.is_branch = 1'b1;
            end
            default: word = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/main_ctrl_dec.sv
module main_ctrl_dec
    import main_ctrl_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    opcode,
    input  logic               alu_zero,
    output logic               dst_sel_rd,
    output logic               alu_b_imm,
    output logic               wb_from_mem,
    output logic               rf_we,
    output logic               dm_re,
    output logic               dm_we,
    output logic [CLASS_W-1:0] alu_class,
    output logic               is_branch,
    output logic               pc_take
);

    instr_kind_e kind;
    ctrl_word_t  table_word;
    ctrl_word_t  ctrl_d;
    ctrl_word_t  ctrl_q;

    main_ctrl_dec_classify #(.W(OP_W)) u_classify (
        .opcode (opcode),
        .kind   (kind)
    );

    main_ctrl_dec_table u_table (
        .kind (kind),
        .word (table_word)
    );

    always_comb begin
        ctrl_d = table_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign dst_sel_rd  = ctrl_q.dst_sel_rd;
    assign alu_b_imm   = ctrl_q.alu_b_imm;
    assign wb_from_mem = ctrl_q.wb_from_mem;
    assign rf_we       = ctrl_q.rf_we;
    assign dm_re       = ctrl_q.dm_re;
    assign dm_we       = ctrl_q.dm_we;
    assign alu_class   = ctrl_q.alu_class;
    assign is_branch   = ctrl_q.is_branch;
    assign pc_take     = ctrl_q.is_branch & alu_zero;

endmodule

// File: rtl/main_ctrl_dec_chk.sv
module main_ctrl_dec_chk
    import main_ctrl_dec_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [OP_W-1:0]    opcode,
    input logic               alu_zero,
    input logic               dst_sel_rd,
    input logic               alu_b_imm,
    input logic               wb_from_mem,
    input logic               rf_we,
    input logic               dm_re,
    input logic               dm_we,
    input logic [CLASS_W-1:0] alu_class,
    input logic               is_branch,
    input logic               pc_take
);

    logic [8:0] word;
    assign word = {dst_sel_rd, alu_b_imm, wb_from_mem, rf_we, dm_re, dm_we, alu_class, is_branch};

    logic known_op;
    assign known_op = (opcode == OPC_RR) || (opcode == OPC_LOAD) ||
                      (opcode == OPC_STORE) || (opcode == OPC_BRANCH);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (word == '0 && !pc_take));

    // R2
    rr_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == OPC_RR) |-> (word == 9'b1_0_0_1_0_0_10_0));

    // R3
    load_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == OPC_LOAD) |-> (word == 9'b0_1_1_1_1_0_00_0));

    // R4
    store_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == OPC_STORE) |-> (word == 9'b0_1_0_0_0_1_00_0));

    // R5
    branch_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == OPC_BRANCH) |-> (word == 9'b0_0_0_0_0_0_01_1));

    // R6
    unknown_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(known_op)) |-> (word == '0));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(opcode) == $past(opcode, 2)) |-> $stable(word));

    // R8
    take_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_take |-> (alu_zero && is_branch));

    // R8
    take_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_branch && alu_zero) |-> pc_take);

    // R9
    write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && dm_we));

    // R9
    read_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_re |-> (rf_we && wb_from_mem));

endmodule

bind main_ctrl_dec main_ctrl_dec_chk u_main_ctrl_dec_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode      (opcode),
    .alu_zero    (alu_zero),
    .dst_sel_rd  (dst_sel_rd),
    .alu_b_imm   (alu_b_imm),
    .wb_from_mem (wb_from_mem),
    .rf_we       (rf_we),
    .dm_re       (dm_re),
    .dm_we       (dm_we),
    .alu_class   (alu_class),
    .is_branch   (is_branch),
    .pc_take     (pc_take)
);

// File: tb/main_ctrl_dec_bench.sv
`timescale 1ns/1ps
module main_ctrl_dec_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic       dst_sel_rd, alu_b_imm, wb_from_mem, rf_we, dm_re, dm_we, is_branch, pc_take;
    logic [1:0] alu_class;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    main_ctrl_dec u_main_ctrl_dec (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .dst_sel_rd(dst_sel_rd), .alu_b_imm(alu_b_imm), .wb_from_mem(wb_from_mem),
        .rf_we(rf_we), .dm_re(dm_re), .dm_we(dm_we), .alu_class(alu_class),
        .is_branch(is_branch), .pc_take(pc_take)
    );

    // {opcode, expected word}; word = {dst,imm,wbmem,rfwe,re,we,class[1:0],br}
    localparam int NV = 8;
    localparam logic [14:0] VEC [NV] = '{
        {6'h00, 9'b1_0_0_1_0_0_10_0},   // R2
        {6'h23, 9'b0_1_1_1_1_0_00_0},   // R3
        {6'h2B, 9'b0_1_0_0_0_1_00_0},   // R4
        {6'h04, 9'b0_0_0_0_0_0_01_1},   // R5
        {6'h3F, 9'b0},                  // R6
        {6'h02, 9'b0},                  // R6
        {6'h05, 9'b0},                  // R6
        {6'h2A, 9'b0}                   // R6
    };

    function automatic logic [8:0] word_now();
        return {dst_sel_rd, alu_b_imm, wb_from_mem, rf_we, dm_re, dm_we, alu_class, is_branch};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [5:0] op);
        case (op)
            6'h00: return "R2";
            6'h23: return "R3";
            6'h2B: return "R4";
            6'h04: return "R5";
            default: return "R6";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        opcode = 6'h23;
        repeat (2) @(negedge clk);
        check("R1", {word_now()}, 9'b0);
        alu_zero = 1'b1;
        #1 check("R1", {8'b0, pc_take}, 9'b0);
        rst_n = 1'b1;
        alu_zero = 1'b0;

        // table walk, each vector with zero flag low then high
        for (int i = 0; i < NV; i++) begin
            opcode = VEC[i][14:9];
            @(negedge clk);
            alu_zero = 1'b0;
            #1 check(req_of(VEC[i][14:9]), word_now(), VEC[i][8:0]);
            check("R8", {8'b0, pc_take}, 9'b0);
            alu_zero = 1'b1;
            #1 check("R8", {8'b0, pc_take}, {8'b0, VEC[i][0]});
            check("R9", {8'b0, rf_we & dm_we}, 9'b0);
            alu_zero = 1'b0;
        end

        // R7: opcode change between edges does not move outputs
        opcode = 6'h04;
        @(negedge clk);
        opcode = 6'h00;
        #2 check("R7", word_now(), 9'b0_0_0_0_0_0_01_1);
        @(negedge clk);
        check("R7", word_now(), 9'b1_0_0_1_0_0_10_0);

        // R6 after a load: illegal code clears the enables
        opcode = 6'h23;
        @(negedge clk);
        opcode = 6'h3E;
        @(negedge clk);
        check("R6", word_now(), 9'b0);

        // R1: reset mid-load clears without a clock edge
        opcode = 6'h23;
        @(negedge clk);
        check("R3", word_now(), 9'b0_1_1_1_1_0_00_0);
        #1 rst_n = 1'b0;
        #1 check("R1", word_now(), 9'b0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule